// File: doc/BRIEF.md
# Timebase Prescaler with Watchdog Timer

This block divides a timebase clock enable stream by one of four selectable ratios and emits a single-cycle timebase tick. The tick sets a sticky interrupt flag, which software acknowledges by writing a one. The same tick also drives a four-state watchdog stage. When that stage overflows and the watchdog is enabled, the block issues a one-cycle reset request to the rest of the chip.

Software keeps the watchdog from firing by writing a one to the clear bit. The clear restarts only the four-state stage and leaves the prescaler running. The timeout after a clear therefore lands between three and four tick periods later. A count-enable input stands for the timebase clock being gated, for example during stop mode. While it is low, both the prescaler and the watchdog stage hold their values.

The watchdog stage is a state machine with states WD_Q0, WD_Q1, WD_Q2 and WD_Q3. It has three named transitions:
- ADVANCE: a tick moves Qn to Qn+1.
- CLEAR: a clear write sends any state to WD_Q0.
- OVERFLOW: a tick in WD_Q3 returns the stage to WD_Q0. If the watchdog is enabled, OVERFLOW also raises the reset request.

Top module: `tbwd_top`

## Requirements
- R1: `rate_sel` selects the tick period in enabled cycles: 0 gives 128, 1 gives 4096, 2 gives 8192 and 3 gives 16384. `tb_tick` is high for exactly one cycle per period, in the cycle after the enabled cycle in which the low log2(ratio) prescaler bits are all ones.
- R2: A change of `rate_sel` does not reset the prescaler. The new ratio applies from the next count. For example, moving from 0 to 1 when the count is 200 gives the next tick when the count reaches 4095.
- R3: After reset, after a clear, or after a reset request, the stage leaves WD_Q3 on the fourth tick. With `rate_sel`=0, timeouts come every 512 enabled cycles.
- R4: With `wd_en` low, OVERFLOW returns the stage to WD_Q0 and no reset request is raised. The stage keeps counting, so a later enable fires on the next overflow.
- R5: A write (`ctl_wr`=1) with `ctl_clr`=1 takes the CLEAR transition. A write with `ctl_clr`=0 leaves the stage unchanged. A clear never touches the prescaler.
- R6: When a clear and an overflow tick fall in the same cycle, the clear wins and no reset request is raised.
- R7: `wd_rst_req` is a one-cycle pulse. The same edge clears the stage and the prescaler.
- R8: While `tb_clk_en` is low, the prescaler and the stage hold their values and no tick occurs. The timeout is delayed by exactly the number of gated cycles.
- R9: A tick sets `tb_flag`. A write with `ctl_ack`=1 clears it, and a write with `ctl_ack`=0 does not. When a tick and an acknowledge fall in the same cycle, the tick wins.
- R10: `tb_irq` equals `tb_flag` AND `irq_en`.
- R11: While reset is applied, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_clk_en | input | 1 | Timebase clock enable; low means the timebase clock is gated |
| rate_sel | input | 2 | Divide-ratio select (0:128, 1:4096, 2:8192, 3:16384) |
| wd_en | input | 1 | Watchdog enable |
| irq_en | input | 1 | Tick interrupt enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_clr | input | 1 | Write data: 1 restarts the watchdog stage |
| ctl_ack | input | 1 | Write data: 1 clears the tick flag |
| tb_tick | output | 1 | One-cycle timebase tick |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |
| tb_flag | output | 1 | Sticky tick interrupt flag |
| tb_irq | output | 1 | Tick interrupt request |

## Verification
A bench cycle counter restarts at reset release and advances on every rising edge.

- `tb_tick` and `tb_flag` rise right after the edge that ends an enabled cycle in which the selected low prescaler bits are all ones. With `rate_sel`=0 from reset, that is edge 128.
- `wd_rst_req` rises on the edge of the fourth tick after a restart.
- A write presented before edge N acts at edge N.
- `tb_irq` follows its inputs in the same cycle.

All outputs are sampled on the falling edge after the counted rising edge. Every expected edge number comes from the ratios, the clear timing and the gated-cycle count. Examples are 512, 640 and 1024 for the watchdog timeouts, and 812 with 300 gated cycles.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;
    typedef enum logic [1:0] {
        WD_Q0 = 2'd0,
        WD_Q1 = 2'd1,
        WD_Q2 = 2'd2,
        WD_Q3 = 2'd3
    } wd_state_t;
endpackage

// File: rtl/tbwd_prescaler.sv
module tbwd_prescaler #(
    parameter int L0 = 7,
    parameter int L1 = 12,
    parameter int L2 = 13,
    parameter int L3 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       cnt_clr,
    input  logic [1:0] rate_sel,
    output logic       tick_c,
    output logic       tick_q
);
    localparam int W = L3;

    logic [W-1:0] cnt;
    logic [W:0]   span;
    int unsigned  sel_log;

    always_comb begin
        unique case (rate_sel)
            2'd0: sel_log = L0;
            2'd1: sel_log = L1;
            2'd2: sel_log = L2;
            default: sel_log = L3;
        endcase
        span   = ((W+1)'(1) << sel_log) - (W+1)'(1);
        tick_c = cnt_en && (&(cnt | ~span[W-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_c;
            if (cnt_clr)
                cnt <= '0;
            else if (cnt_en)
                cnt <= cnt + W'(1);
        end
    end

    // R8: gated timebase freezes the count
    p_hold_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(cnt));
    // R8: no tick follows a gated cycle
    p_no_tick_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> !tick_q);
    // R1: tick is a single-cycle pulse
    p_tick_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog
    import tbwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_c,
    input  logic wd_en,
    input  logic clr_req,
    output logic fire_c,
    output logic wd_rst_req
);
    wd_state_t stage, stage_nx;

    always_comb begin
        stage_nx = stage;
        if (clr_req) begin
            stage_nx = WD_Q0;                  // CLEAR
        end else if (tick_c) begin
            unique case (stage)
                WD_Q0: stage_nx = WD_Q1;       // ADVANCE
                WD_Q1: stage_nx = WD_Q2;
                WD_Q2: stage_nx = WD_Q3;
                WD_Q3: stage_nx = WD_Q0;       // OVERFLOW
            endcase
        end
        fire_c = tick_c && !clr_req && wd_en && (stage == WD_Q3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= WD_Q0;
        else        stage <= stage_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_rst_req <= 1'b0;
        else        wd_rst_req <= fire_c;
    end

    // R7: reset request lasts one cycle
    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);
    // R7: reset request leaves the stage in WD_Q0
    p_rst_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (stage == WD_Q0));
    // R4: request only when enabled in the previous cycle
    p_rst_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> $past(wd_en));
    // R5, R6: a clear restarts the stage and suppresses the request
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (stage == WD_Q0) && !wd_rst_req);
endmodule

// File: rtl/tbwd_irq.sv
module tbwd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_c,
    input  logic tick_q,
    input  logic ack_req,
    input  logic irq_en,
    output logic tb_flag,
    output logic tb_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tb_flag <= 1'b0;
        else if (tick_c)  tb_flag <= 1'b1;
        else if (ack_req) tb_flag <= 1'b0;
    end

    assign tb_irq = tb_flag & irq_en;

    // R9: a tick leaves the flag set
    p_flag_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> tb_flag);
    // R9: a flag that was clear rises only through a tick
    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tb_flag) |-> tick_q);
    // R10: interrupt is gated by the enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tb_irq |-> (tb_flag && irq_en));
endmodule

// File: rtl/tbwd_top.sv
module tbwd_top #(
    parameter int L0 = 7,
    parameter int L1 = 12,
    parameter int L2 = 13,
    parameter int L3 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_clk_en,
    input  logic [1:0] rate_sel,
    input  logic       wd_en,
    input  logic       irq_en,
    input  logic       ctl_wr,
    input  logic       ctl_clr,
    input  logic       ctl_ack,
    output logic       tb_tick,
    output logic       wd_rst_req,
    output logic       tb_flag,
    output logic       tb_irq
);
    logic tick_c;
    logic fire_c;
    logic clr_req;
    logic ack_req;

    assign clr_req = ctl_wr & ctl_clr;
    assign ack_req = ctl_wr & ctl_ack;

    tbwd_prescaler #(.L0(L0), .L1(L1), .L2(L2), .L3(L3)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (tb_clk_en),
        .cnt_clr  (fire_c),
        .rate_sel (rate_sel),
        .tick_c   (tick_c),
        .tick_q   (tb_tick)
    );

    tbwd_watchdog u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_c     (tick_c),
        .wd_en      (wd_en),
        .clr_req    (clr_req),
        .fire_c     (fire_c),
        .wd_rst_req (wd_rst_req)
    );

    tbwd_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_c  (tick_c),
        .tick_q  (tb_tick),
        .ack_req (ack_req),
        .irq_en  (irq_en),
        .tb_flag (tb_flag),
        .tb_irq  (tb_irq)
    );

    // R7: a reset request coincides with a tick
    p_rst_with_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> tb_tick);
endmodule

// File: tb/tbwd_top_bench.sv
module tbwd_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_clk_en = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       wd_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_clr = 1'b0;
    logic       ctl_ack = 1'b0;
    logic       tb_tick, wd_rst_req, tb_flag, tb_irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    tbwd_top u_tbwd_top (
        .clk(clk), .rst_n(rst_n), .tb_clk_en(tb_clk_en), .rate_sel(rate_sel),
        .wd_en(wd_en), .irq_en(irq_en), .ctl_wr(ctl_wr), .ctl_clr(ctl_clr),
        .ctl_ack(ctl_ack), .tb_tick(tb_tick), .wd_rst_req(wd_rst_req),
        .tb_flag(tb_flag), .tb_irq(tb_irq)
    );

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;
    always @(negedge clk) if (tb_tick) tick_cnt <= tick_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tb_clk_en = 1'b1; rate_sel = 2'd0; wd_en = 1'b0;
        irq_en = 1'b0; ctl_wr = 1'b0; ctl_clr = 1'b0; ctl_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic wait_rst(output int at);
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!wd_rst_req && guard < 40000);
        at = cyc;
    endtask

    task automatic wait_tick(output int at);
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!tb_tick && guard < 40000);
        at = cyc;
    endtask

    task automatic write_ctl(input bit clr, input bit ack);
        ctl_wr = 1'b1; ctl_clr = clr; ctl_ack = ack;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_clr = 1'b0; ctl_ack = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; irq_en = 1'b1; wd_en = 1'b1;
        repeat (2) @(negedge clk);
        check({tb_tick, wd_rst_req, tb_flag, tb_irq} == 4'b0, "R11 outputs in reset",
              {tb_tick, wd_rst_req, tb_flag, tb_irq}, 0);
    endtask

    task automatic t_rates();
        int a, b;
        int expv;
        do_reset();
        wait_tick(a);
        check(a == 128, "R1 first tick at rate 0", a, 128);
        @(negedge clk);
        check(tb_tick == 1'b0, "R1 tick single cycle", tb_tick, 0);
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            wait_tick(a);
            wait_tick(b);
            expv = (r == 0) ? 128 : (r == 1) ? 4096 : (r == 2) ? 8192 : 16384;
            check((b - a) == expv, "R1 tick period", b - a, expv);
        end
    endtask

    task automatic t_rate_switch();
        int a;
        do_reset();
        wait_cyc(200);
        rate_sel = 2'd1;
        wait_tick(a);
        check(a == 4096, "R2 rate change keeps count", a, 4096);
    endtask

    task automatic t_timeout();
        int a, b;
        do_reset();
        wd_en = 1'b1;
        wait_rst(a);
        check(a == 512, "R3 first timeout", a, 512);
        @(negedge clk);
        check(wd_rst_req == 1'b0, "R7 request one cycle", wd_rst_req, 0);
        wait_rst(b);
        check(b - a == 512, "R3 repeated timeout", b - a, 512);
        wd_en = 1'b0; rate_sel = 2'd1;
        wait_tick(a);
        check(a - b == 4096, "R7 prescaler cleared by request", a - b, 4096);
    endtask

    task automatic t_disabled();
        int a;
        int t0;
        do_reset();
        t0 = tick_cnt;
        wait_cyc(2000);
        check(tick_cnt - t0 == 15, "R4 ticks continue when disabled", tick_cnt - t0, 15);
        wd_en = 1'b1;
        wait_rst(a);
        check(a == 2048, "R4 stage kept counting while disabled", a, 2048);
    endtask

    task automatic t_clear();
        int a;
        do_reset();
        wd_en = 1'b1;
        wait_cyc(200);
        write_ctl(1'b0, 1'b0);
        wait_rst(a);
        check(a == 512, "R5 clear written as 0 ignored", a, 512);
        do_reset();
        wd_en = 1'b1;
        wait_cyc(200);
        write_ctl(1'b1, 1'b0);
        wait_rst(a);
        check(a == 640, "R5 clear restarts stage only", a, 640);
    endtask

    task automatic t_clear_race();
        int a;
        bit seen = 1'b0;
        do_reset();
        wd_en = 1'b1;
        wait_cyc(511);
        write_ctl(1'b1, 1'b0);
        seen = wd_rst_req;
        check(seen == 1'b0, "R6 no request on clear overflow race", seen, 0);
        wait_rst(a);
        check(a == 1024, "R6 clear wins over overflow", a, 1024);
    endtask

    task automatic t_freeze();
        int a;
        int t0;
        do_reset();
        wd_en = 1'b1;
        wait_cyc(100);
        tb_clk_en = 1'b0;
        t0 = tick_cnt;
        wait_cyc(400);
        check(tick_cnt == t0, "R8 no tick while gated", tick_cnt - t0, 0);
        tb_clk_en = 1'b1;
        wait_tick(a);
        check(a == 428, "R8 tick delayed by gated cycles", a, 428);
        wait_rst(a);
        check(a == 812, "R8 timeout stretched", a, 812);
    endtask

    task automatic t_irq();
        int a;
        do_reset();
        wait_tick(a);
        check(tb_flag == 1'b1 && tb_irq == 1'b0, "R9 flag set, R10 irq masked",
              {tb_flag, tb_irq}, 2);
        irq_en = 1'b1;
        #1;
        check(tb_irq == 1'b1, "R10 irq follows enable", tb_irq, 1);
        write_ctl(1'b0, 1'b0);
        check(tb_flag == 1'b1, "R9 ack written as 0 ignored", tb_flag, 1);
        wait_cyc(255);
        write_ctl(1'b0, 1'b1);
        check(tb_flag == 1'b1, "R9 tick wins over ack", tb_flag, 1);
        write_ctl(1'b0, 1'b1);
        check(tb_flag == 1'b0 && tb_irq == 1'b0, "R9 ack clears flag",
              {tb_flag, tb_irq}, 0);
    endtask

    initial begin
        #(150000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_rates();
        t_rate_switch();
        t_timeout();
        t_disabled();
        t_clear();
        t_clear_race();
        t_freeze();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule